// File: doc/BRIEF.md
# Breakpoint Trigger Sequencer

This block sits in a processor's debug unit, downstream of two address comparators. Each cycle it receives a match pulse from each comparator and a strobe that marks a retired instruction. A 5-bit mode code and a loadable occurrence count are written together, and they set how the two matches combine into one final debug trigger. The matches can be counted alone, ORed, ANDed or chained in a fixed order. They can also arm an instruction-count trace that ends in the trigger. One mode sends comparator 2 matches to a separate debug-interrupt pulse.

The same configuration write loads a 2-bit breakpoint-enable field, a mask for the external debug-request input and an enable for an active-low event pin. Debug entry is requested for one cycle when the trigger fires, or when an external request arrives while the mask is clear. Every output is registered. A stimulus sampled at one rising edge shows on the outputs just after that edge.

Top module: `bkpt_trigger_seq`

## Requirements
- R1: After reset, trigPulse, intPulse and debugEntry are 0 and eventPinN is 1. The stored mode is unlisted, so the sequencer is idle. The request mask is set, so extDebugReq has no effect.
- R2: Mode 5'b00000 fires trigPulse one cycle after the edge at which bp1Hit has been seen for the programmed count. bp2Hit is ignored in this mode.
- R3: Mode 5'b00001 counts cycles with bp1Hit or bp2Hit. Mode 5'b00010 counts only cycles where both are high together. Each mode fires trigPulse when the count is reached.
- R4: Mode 5'b00100 fires trigPulse on the first bp1Hit. Every bp2Hit gives an intPulse one cycle later, including after the trigger has fired and in the same cycle as the trigger.
- R5: Mode 5'b01011 ignores bp1Hit until one bp2Hit has occurred. After that, bp1Hit must reach the programmed count to fire trigPulse.
- R6: Mode 5'b01111 ignores bp1Hit until bp2Hit has reached the programmed count. After that, a single bp1Hit fires trigPulse.
- R7: Modes 5'b10000, 5'b10001 and 5'b10010 wait for one event: bp1Hit, then bp1Hit or bp2Hit, then both together, respectively. From the next cycle on they count instRetired strobes, and trigPulse fires when the programmed count is reached.
- R8: Mode 5'b10100 acts like 5'b10000, and in addition every bp2Hit gives an intPulse. Mode 5'b10111 counts instRetired from the configuration write, with no breakpoint needed.
- R9: Mode 5'b11011 needs one bp2Hit, then one bp1Hit, then the programmed count of instRetired strobes before trigPulse fires.
- R10: A breakpoint-enable field of 2'b00 blocks the trigger and the interrupt in every mode except 5'b10111.
- R11: A configuration write restarts the sequence from its first stage, and no output fires in the cycle after the write. A count of 0 acts as 1. Unlisted mode codes produce no outputs.
- R12: After trigPulse fires, the sequencer stays done and produces no further trigger until the next configuration write.
- R13: debugEntry pulses one cycle after a trigger, or one cycle after extDebugReq is seen while the request mask is 0. A trigger and a request in the same cycle give a single pulse. With the mask at 1, extDebugReq is ignored.
- R14: eventPinN goes low for one cycle with each trigPulse or intPulse, but only when the mask is 0 and pin drive is 1. Otherwise it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe; loads all cfg fields and restarts |
| cfgMode | input | 5 | Trigger combination code |
| cfgCount | input | CNT_W | Occurrence or instruction count (0 acts as 1) |
| cfgBpEn | input | 2 | Breakpoint enable; 00 disables all but pure trace |
| cfgReqMask | input | 1 | 1 masks extDebugReq and event pin drive |
| cfgPinDrive | input | 1 | 1 lets events drive eventPinN low |
| bp1Hit | input | 1 | Comparator 1 match pulse |
| bp2Hit | input | 1 | Comparator 2 match pulse |
| instRetired | input | 1 | One instruction retired this cycle |
| extDebugReq | input | 1 | External debug request pulse |
| trigPulse | output | 1 | Final trigger, single cycle |
| intPulse | output | 1 | Debug interrupt from comparator 2 |
| debugEntry | output | 1 | Debug state entry request |
| eventPinN | output | 1 | Active-low event pin drive |

## Verification
The final trigger and the debug interrupt can land in the same cycle. In mode 5'b00100, both comparator pulses are raised in one cycle, and the bench expects trigPulse and intPulse together with a single low cycle on eventPinN. The trigger and an unmasked external request can also coincide. That case is provoked by raising extDebugReq together with the firing bp1Hit, and it is judged by exactly one debugEntry cycle. The scoreboard holds one expected output set per stimulus cycle, so a doubled or missing pulse shows up as a mismatch.

// File: rtl/bkpt_trigger_seq_pkg.sv
package bkpt_trigger_seq_pkg;

  typedef enum logic [2:0] {
    STG_IDLE,
    STG_FIRST,
    STG_SECOND,
    STG_TRACE,
    STG_DONE
  } stage_e;

  localparam logic [4:0] MODE_B1_CNT    = 5'b00000;
  localparam logic [4:0] MODE_OR_CNT    = 5'b00001;
  localparam logic [4:0] MODE_AND_CNT   = 5'b00010;
  localparam logic [4:0] MODE_B1_IRQ    = 5'b00100;
  localparam logic [4:0] MODE_B2_B1CNT  = 5'b01011;
  localparam logic [4:0] MODE_B2CNT_B1  = 5'b01111;
  localparam logic [4:0] MODE_B1_TRC    = 5'b10000;
  localparam logic [4:0] MODE_OR_TRC    = 5'b10001;
  localparam logic [4:0] MODE_AND_TRC   = 5'b10010;
  localparam logic [4:0] MODE_B1_TRC_IRQ = 5'b10100;
  localparam logic [4:0] MODE_TRC_ONLY  = 5'b10111;
  localparam logic [4:0] MODE_B2_B1_TRC = 5'b11011;
  localparam logic [4:0] MODE_RESET     = 5'b11111;

  typedef struct packed {
    logic reload;
    logic dec;
    logic fire;
    logic irq;
  } seqStrobe_t;

  function automatic logic modeLegal(input logic [4:0] m);
    case (m)
      MODE_B1_CNT, MODE_OR_CNT, MODE_AND_CNT, MODE_B1_IRQ,
      MODE_B2_B1CNT, MODE_B2CNT_B1, MODE_B1_TRC, MODE_OR_TRC,
      MODE_AND_TRC, MODE_B1_TRC_IRQ, MODE_TRC_ONLY, MODE_B2_B1_TRC:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic stage_e startStage(input logic [4:0] m, input logic [1:0] en);
    if (!modeLegal(m))          return STG_IDLE;
    else if (m == MODE_TRC_ONLY) return STG_TRACE;
    else if (en == 2'b00)       return STG_IDLE;
    else                        return STG_FIRST;
  endfunction

endpackage

// File: rtl/bkpt_trigger_seq_ctrl.sv
module bkpt_trigger_seq_ctrl
  import bkpt_trigger_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [4:0] cfgMode,
  input  logic [1:0] cfgBpEn,
  input  logic       bp1Hit,
  input  logic       bp2Hit,
  input  logic       instRetired,
  input  logic       cntLast,
  output seqStrobe_t strobe
);

  logic [4:0] modeQ;
  stage_e     stageQ;
  stage_e     nextStg;
  logic       evt;
  logic       counted;
  logic       advance;
  logic       bpOr;
  logic       bpAnd;
  logic       irqMode;

  assign bpOr    = bp1Hit | bp2Hit;
  assign bpAnd   = bp1Hit & bp2Hit;
  assign irqMode = (modeQ == MODE_B1_IRQ) || (modeQ == MODE_B1_TRC_IRQ);

  always_comb begin
    evt     = 1'b0;
    counted = 1'b0;
    nextStg = STG_DONE;
    case (stageQ)
      STG_FIRST: begin
        case (modeQ)
          MODE_B1_CNT:   begin evt = bp1Hit; counted = 1'b1; end
          MODE_OR_CNT:   begin evt = bpOr;   counted = 1'b1; end
          MODE_AND_CNT:  begin evt = bpAnd;  counted = 1'b1; end
          MODE_B1_IRQ:   begin evt = bp1Hit; end
          MODE_B2_B1CNT: begin evt = bp2Hit; nextStg = STG_SECOND; end
          MODE_B2CNT_B1: begin evt = bp2Hit; counted = 1'b1; nextStg = STG_SECOND; end
          MODE_B1_TRC, MODE_B1_TRC_IRQ: begin evt = bp1Hit; nextStg = STG_TRACE; end
          MODE_OR_TRC:   begin evt = bpOr;   nextStg = STG_TRACE; end
          MODE_AND_TRC:  begin evt = bpAnd;  nextStg = STG_TRACE; end
          MODE_B2_B1_TRC: begin evt = bp2Hit; nextStg = STG_SECOND; end
          default:       evt = 1'b0;
        endcase
      end
      STG_SECOND: begin
        case (modeQ)
          MODE_B2_B1CNT:  begin evt = bp1Hit; counted = 1'b1; end
          MODE_B2CNT_B1:  begin evt = bp1Hit; end
          MODE_B2_B1_TRC: begin evt = bp1Hit; nextStg = STG_TRACE; end
          default:        evt = 1'b0;
        endcase
      end
      STG_TRACE: begin
        evt     = instRetired;
        counted = 1'b1;
      end
      default: evt = 1'b0;
    endcase
  end

  assign advance       = !cfgWe && evt && (!counted || cntLast);
  assign strobe.dec    = !cfgWe && evt && counted && !cntLast;
  assign strobe.reload = advance && (nextStg != STG_DONE);
  assign strobe.fire   = advance && (nextStg == STG_DONE);
  assign strobe.irq    = !cfgWe && bp2Hit && irqMode && (stageQ != STG_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_RESET;
      stageQ <= STG_IDLE;
    end else if (cfgWe) begin
      modeQ  <= cfgMode;
      stageQ <= startStage(cfgMode, cfgBpEn);
    end else if (advance) begin
      stageQ <= nextStg;
    end
  end

endmodule

// File: rtl/bkpt_trigger_seq_dp.sv
module bkpt_trigger_seq_dp
  import bkpt_trigger_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgReqMask,
  input  logic             cfgPinDrive,
  input  logic             extDebugReq,
  input  seqStrobe_t       strobe,
  output logic             cntLast,
  output logic             trigPulse,
  output logic             intPulse,
  output logic             debugEntry,
  output logic             eventPinN
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] remQ;
  logic             maskQ;
  logic             driveQ;
  logic             pinEvent;

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_ONE : v;
  endfunction

  assign cntLast  = (remQ <= CNT_ONE);
  assign pinEvent = (strobe.fire | strobe.irq) & ~maskQ & driveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= CNT_ONE;
      remQ   <= CNT_ONE;
      maskQ  <= 1'b1;
      driveQ <= 1'b0;
    end else if (cfgWe) begin
      countQ <= cfgCount;
      remQ   <= atLeastOne(cfgCount);
      maskQ  <= cfgReqMask;
      driveQ <= cfgPinDrive;
    end else if (strobe.reload) begin
      remQ <= atLeastOne(countQ);
    end else if (strobe.dec) begin
      remQ <= remQ - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPulse  <= 1'b0;
      intPulse   <= 1'b0;
      debugEntry <= 1'b0;
      eventPinN  <= 1'b1;
    end else begin
      trigPulse  <= strobe.fire;
      intPulse   <= strobe.irq;
      debugEntry <= strobe.fire | (extDebugReq & ~maskQ);
      eventPinN  <= ~pinEvent;
    end
  end

endmodule

// File: rtl/bkpt_trigger_seq.sv
module bkpt_trigger_seq
  import bkpt_trigger_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [4:0]       cfgMode,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic [1:0]       cfgBpEn,
  input  logic             cfgReqMask,
  input  logic             cfgPinDrive,
  input  logic             bp1Hit,
  input  logic             bp2Hit,
  input  logic             instRetired,
  input  logic             extDebugReq,
  output logic             trigPulse,
  output logic             intPulse,
  output logic             debugEntry,
  output logic             eventPinN
);

  seqStrobe_t strobe;
  logic       cntLast;

  bkpt_trigger_seq_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgMode     (cfgMode),
    .cfgBpEn     (cfgBpEn),
    .bp1Hit      (bp1Hit),
    .bp2Hit      (bp2Hit),
    .instRetired (instRetired),
    .cntLast     (cntLast),
    .strobe      (strobe)
  );

  bkpt_trigger_seq_dp #(.CNT_W(CNT_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgCount    (cfgCount),
    .cfgReqMask  (cfgReqMask),
    .cfgPinDrive (cfgPinDrive),
    .extDebugReq (extDebugReq),
    .strobe      (strobe),
    .cntLast     (cntLast),
    .trigPulse   (trigPulse),
    .intPulse    (intPulse),
    .debugEntry  (debugEntry),
    .eventPinN   (eventPinN)
  );

endmodule

// File: rtl/bkpt_trigger_seq_chk.sv
module bkpt_trigger_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cfgWe,
  input logic bp2Hit,
  input logic extDebugReq,
  input logic trigPulse,
  input logic intPulse,
  input logic debugEntry,
  input logic eventPinN
);

  // R12
  single_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R11
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (!trigPulse && !intPulse));

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    intPulse |-> $past(bp2Hit));

  // R14
  pin_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !eventPinN |-> (trigPulse || intPulse));

  // R13
  entry_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    debugEntry |-> (trigPulse || $past(extDebugReq)));

endmodule

bind bkpt_trigger_seq bkpt_trigger_seq_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWe       (cfgWe),
  .bp2Hit      (bp2Hit),
  .extDebugReq (extDebugReq),
  .trigPulse   (trigPulse),
  .intPulse    (intPulse),
  .debugEntry  (debugEntry),
  .eventPinN   (eventPinN)
);

// File: tb/bkpt_trigger_seq_tb_top.sv
module bkpt_trigger_seq_tb_top;

  localparam int CLK_P = 10;
  localparam int CNT_W = 8;

  typedef struct {
    logic  trig;
    logic  irq;
    logic  entry;
    logic  pinN;
    string tag;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [4:0]       cfgMode = '0;
  logic [CNT_W-1:0] cfgCount = '0;
  logic [1:0]       cfgBpEn = '0;
  logic             cfgReqMask = 1'b1;
  logic             cfgPinDrive = 1'b0;
  logic             bp1Hit = 1'b0;
  logic             bp2Hit = 1'b0;
  logic             instRetired = 1'b0;
  logic             extDebugReq = 1'b0;
  logic             trigPulse;
  logic             intPulse;
  logic             debugEntry;
  logic             eventPinN;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bkpt_trigger_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgCount(cfgCount), .cfgBpEn(cfgBpEn), .cfgReqMask(cfgReqMask),
    .cfgPinDrive(cfgPinDrive), .bp1Hit(bp1Hit), .bp2Hit(bp2Hit),
    .instRetired(instRetired), .extDebugReq(extDebugReq),
    .trigPulse(trigPulse), .intPulse(intPulse), .debugEntry(debugEntry),
    .eventPinN(eventPinN)
  );

  task automatic step(input logic b1, input logic b2, input logic ins, input logic ext,
                      input logic eT, input logic eI, input logic eE, input logic eP,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    cfgWe = 1'b0;
    bp1Hit = b1; bp2Hit = b2; instRetired = ins; extDebugReq = ext;
    it.trig = eT; it.irq = eI; it.entry = eE; it.pinN = eP; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic none(input logic b1, input logic b2, input logic ins, input string tag);
    step(b1, b2, ins, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic cfg(input logic [4:0] m, input int cnt, input logic [1:0] en,
                     input logic msk, input logic drv);
    expItem_t it;
    @(negedge clk);
    cfgWe = 1'b1; cfgMode = m; cfgCount = CNT_W'(cnt); cfgBpEn = en;
    cfgReqMask = msk; cfgPinDrive = drv;
    bp1Hit = 1'b0; bp2Hit = 1'b0; instRetired = 1'b0; extDebugReq = 1'b0;
    it.trig = 1'b0; it.irq = 1'b0; it.entry = 1'b0; it.pinN = 1'b1; it.tag = "R11 cfg write";
    expQ.push_back(it);
  endtask

  // monitor: compare outputs just after each edge with the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (trigPulse !== it.trig || intPulse !== it.irq ||
            debugEntry !== it.entry || eventPinN !== it.pinN) begin
          failures++;
          $display("FAIL %s: actual trig=%b int=%b entry=%b pinN=%b expected trig=%b int=%b entry=%b pinN=%b",
                   it.tag, trigPulse, intPulse, debugEntry, eventPinN,
                   it.trig, it.irq, it.entry, it.pinN);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, masked external request
    none(0, 0, 0, "R1 idle");
    step(0, 0, 0, 1, 0, 0, 0, 1, "R1 masked request");
    none(1, 1, 1, "R1 unlisted mode idle");

    // R2
    cfg(5'b00000, 3, 2'b11, 1'b0, 1'b1);
    none(1, 0, 0, "R2 bp1 #1");
    none(0, 1, 0, "R2 bp2 ignored");
    none(1, 0, 0, "R2 bp1 #2");
    step(1, 0, 0, 0, 1, 0, 1, 0, "R2 bp1 #3 fires");
    none(1, 0, 0, "R12 no second trigger");
    none(0, 0, 0, "R12 done holds");

    // R3
    cfg(5'b00001, 2, 2'b11, 1'b0, 1'b1);
    none(0, 1, 0, "R3 or bp2");
    step(1, 0, 0, 0, 1, 0, 1, 0, "R3 or fires");
    cfg(5'b00010, 2, 2'b11, 1'b0, 1'b1);
    none(1, 0, 0, "R3 and bp1 alone");
    none(0, 1, 0, "R3 and bp2 alone");
    none(1, 1, 0, "R3 and both #1");
    step(1, 1, 0, 0, 1, 0, 1, 0, "R3 and both fires");

    // R4
    cfg(5'b00100, 5, 2'b11, 1'b0, 1'b1);
    step(0, 1, 0, 0, 0, 1, 0, 0, "R4 bp2 interrupt");
    step(1, 1, 0, 0, 1, 1, 1, 0, "R4 trigger with interrupt");
    step(0, 1, 0, 0, 0, 1, 0, 0, "R4 interrupt after done");
    none(1, 0, 0, "R12 bp1 after done");

    // R5
    cfg(5'b01011, 2, 2'b11, 1'b0, 1'b1);
    none(1, 0, 0, "R5 bp1 before bp2");
    none(0, 1, 0, "R5 bp2 arms");
    none(1, 0, 0, "R5 bp1 #1");
    step(1, 0, 0, 0, 1, 0, 1, 0, "R5 bp1 #2 fires");

    // R6
    cfg(5'b01111, 2, 2'b11, 1'b0, 1'b1);
    none(1, 0, 0, "R6 bp1 early");
    none(0, 1, 0, "R6 bp2 #1");
    none(0, 1, 0, "R6 bp2 #2");
    step(1, 0, 0, 0, 1, 0, 1, 0, "R6 bp1 fires");

    // R7
    cfg(5'b10000, 3, 2'b11, 1'b0, 1'b1);
    none(0, 0, 1, "R7 inst before arm");
    none(1, 0, 0, "R7 bp1 arms");
    none(0, 0, 1, "R7 inst #1");
    none(0, 0, 1, "R7 inst #2");
    step(0, 0, 1, 0, 1, 0, 1, 0, "R7 inst #3 fires");
    cfg(5'b10001, 1, 2'b11, 1'b0, 1'b1);
    none(0, 1, 0, "R7 or arms");
    step(0, 0, 1, 0, 1, 0, 1, 0, "R7 or trace fires");
    cfg(5'b10010, 2, 2'b11, 1'b0, 1'b1);
    none(1, 0, 0, "R7 and bp1 alone");
    none(1, 1, 0, "R7 and arms");
    none(0, 0, 1, "R7 and inst #1");
    step(0, 0, 1, 0, 1, 0, 1, 0, "R7 and trace fires");

    // R8
    cfg(5'b10100, 1, 2'b11, 1'b0, 1'b1);
    step(0, 1, 0, 0, 0, 1, 0, 0, "R8 bp2 interrupt");
    none(1, 0, 0, "R8 bp1 arms");
    step(0, 0, 1, 0, 1, 0, 1, 0, "R8 trace fires");
    cfg(5'b10111, 2, 2'b00, 1'b0, 1'b1);
    none(0, 0, 1, "R8 pure trace inst #1");
    step(0, 0, 1, 0, 1, 0, 1, 0, "R10 pure trace fires with enable 00");

    // R9
    cfg(5'b11011, 1, 2'b11, 1'b0, 1'b1);
    none(1, 0, 0, "R9 bp1 first ignored");
    none(0, 1, 0, "R9 bp2");
    none(0, 0, 1, "R9 inst before bp1");
    none(1, 0, 0, "R9 bp1 arms trace");
    step(0, 0, 1, 0, 1, 0, 1, 0, "R9 trace fires");

    // R10
    cfg(5'b00000, 1, 2'b00, 1'b0, 1'b1);
    none(1, 0, 0, "R10 count mode disabled");
    cfg(5'b00100, 1, 2'b00, 1'b0, 1'b1);
    none(0, 1, 0, "R10 interrupt disabled");
    none(1, 0, 0, "R10 trigger disabled");

    // R11
    cfg(5'b00000, 0, 2'b11, 1'b0, 1'b1);
    step(1, 0, 0, 0, 1, 0, 1, 0, "R11 count zero as one");
    cfg(5'b00000, 2, 2'b11, 1'b0, 1'b1);
    none(1, 0, 0, "R11 partial count");
    cfg(5'b00000, 2, 2'b11, 1'b0, 1'b1);
    none(1, 0, 0, "R11 restarted count #1");
    step(1, 0, 0, 0, 1, 0, 1, 0, "R11 restarted count fires");
    cfg(5'b00011, 1, 2'b11, 1'b0, 1'b1);
    none(1, 1, 1, "R11 unlisted code");
    none(1, 0, 0, "R11 unlisted code bp1");

    // R13
    cfg(5'b00000, 1, 2'b11, 1'b0, 1'b1);
    step(0, 0, 0, 1, 0, 0, 1, 1, "R13 unmasked request");
    step(1, 0, 0, 1, 1, 0, 1, 0, "R13 request with trigger");
    none(0, 0, 0, "R13 single entry pulse");

    // R14
    cfg(5'b00000, 1, 2'b11, 1'b1, 1'b1);
    step(0, 0, 0, 1, 0, 0, 0, 1, "R13 masked request");
    step(1, 0, 0, 0, 1, 0, 1, 1, "R14 mask blocks pin");
    cfg(5'b00100, 1, 2'b11, 1'b0, 1'b0);
    step(0, 1, 0, 0, 0, 1, 0, 1, "R14 drive off keeps pin high");

    none(0, 0, 0, "drain");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule